// File: doc/BRIEF.md
# Pulse-Gap Downlink Encoder for a Low-Frequency Reader

This block sends commands from a low-frequency reader to a passive tag by switching the reader carrier on and off. A bit is coded by how long the carrier stays on. Short carrier-off gaps separate the bits. A command arrives as one request word on a valid/ready handshake. The block drives `carrier_en` through the whole frame and then through a closing carrier window. It reports completion with a one-cycle `done` pulse.

A request selects one of three commands:
- a block write, which carries a data word and a block number;
- a block read, which carries a block number;
- a page-1 trace read.

A 32-bit password can be put in front of the write and read fields. Every duration is a count of microsecond ticks, and a prescaler makes these ticks from the system clock.

After a write, the carrier stays on long enough for the tag to program its memory. After either kind of read, the carrier stays on for a short settling window. The block then strobes `capture_start`, so that a separate receive path can start sampling.

`req_ready` is high only while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester sees back-pressure for the whole length of a frame. While `req_ready` is low, `req_valid` and the request fields are ignored.

Top module: `pgap_downlink_enc`

## Requirements
- R1: After reset, and in every cycle while idle, `carrier_en`, `busy`, `done` and `capture_start` are 0 and `req_ready` is 1.
- R2: A request is taken on an edge where `req_valid` and `req_ready` are both 1, and `busy` is 1 from the next cycle. While busy, `req_ready` is 0 and any request has no effect on the waveform.
- R3: Each frame opens with the carrier off for START_US microseconds (default 248), counted from the first busy cycle.
- R4: A 0 bit is carrier-on for ZERO_US (default 144) and a 1 bit is carrier-on for ONE_US (default 400). Every bit, the last one included, is followed by a carrier-off gap of GAP_US (default 160).
- R5: `req_cmd` 2'b00 is a block write. Its bits are sent in this order: 1, 0, the optional password, a lock bit of 0, `req_data` bits 31 down to 0, then the block number bits 2 down to 0.
- R6: `req_cmd` 2'b01 is a block read. Its bits are sent in this order: 1, 0, the optional password, a 0 separator, then the block number bits 2 down to 0.
- R7: `req_cmd` 2'b10 or 2'b11 is a trace read. It sends only the bits 1, 1, and ignores the password, data and address.
- R8: When `req_pwd_en` is 1 in a write or read, the 32 bits of `req_pwd` follow the opcode, bit 31 first. When `req_pwd_en` is 0, no password bits are sent.
- R9: The block number is `req_addr[2:0]`. The higher address bits have no effect.
- R10: After a write frame, the carrier is on for HOLD_US (default 20000) and then turns off, with no `capture_start`.
- R11: After a read or trace frame, the carrier is on for LISTEN_US (default 416). `capture_start` then pulses for one cycle, in the same cycle as `done`.
- R12: `done` is a one-cycle pulse. It comes in the first cycle after the final carrier window, and in that cycle `busy` and `carrier_en` are already 0.
- R13: Every duration lasts exactly its microsecond count times CLK_PER_US clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_cmd | input | 2 | 00 write, 01 read, 1x trace read |
| req_data | input | 32 | Data word for a write |
| req_addr | input | ADDR_IN_W | Block address; only bits 2:0 are used |
| req_pwd | input | 32 | Password |
| req_pwd_en | input | 1 | Send the password |
| carrier_en | output | 1 | Reader carrier enable |
| busy | output | 1 | Frame or closing window in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| capture_start | output | 1 | One-cycle strobe to start capturing the tag reply |

## Verification
The carrier waveform shows any fault in the internal state directly:
- A wrong shift register or bit counter turns one carrier-on run into the other bit length, or adds or drops a run. The bench sees this at the first wrong run, less than a millisecond after the fault.
- A prescaler or timer fault stretches or shortens every run, starting with the start gap.
- A wrong closing-window choice shows as a hold or listen run of the wrong length at the end of the frame, or as a `capture_start` present or missing beside `done`.

The scoreboard compares each run's level and length exactly against the sequence it expects. It also checks that `done` arrives in the cycle the closing window ends.

// File: rtl/pgap_pkg.sv
package pgap_pkg;
  localparam int WORD_W = 32;
  localparam int BLK_W  = 3;
  localparam int FRAME_W = 2 + WORD_W + 1 + WORD_W + BLK_W;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SGAP,
    ST_MARK,
    ST_SPACE,
    ST_POST
  } pgap_state_e;

  localparam logic [1:0] CMD_WRITE = 2'b00;
  localparam logic [1:0] CMD_READ  = 2'b01;
endpackage

// File: rtl/pgap_us_tick.sv
module pgap_us_tick #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt <= '0;
    else if (restart)         cnt <= TOP;
    else if (cnt == '0)       cnt <= TOP;
    else                      cnt <= cnt - 1'b1;
  end

  assign tick = (cnt == '0);
endmodule

// File: rtl/pgap_seg_timer.sv
module pgap_seg_timer #(
  parameter int DUR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DUR_W-1:0] load_us,
  input  logic             tick,
  output logic             expire
);
  logic [DUR_W-1:0] us_left;

  always_ff @(posedge clk) begin
    if (!rst_n)                        us_left <= '0;
    else if (load)                     us_left <= load_us;
    else if (tick && us_left != '0)    us_left <= us_left - 1'b1;
  end

  assign expire = tick && (us_left == DUR_W'(1));
endmodule

// File: rtl/pgap_frame_build.sv
module pgap_frame_build
  import pgap_pkg::*;
(
  input  logic [1:0]         cmd,
  input  logic [WORD_W-1:0]  data,
  input  logic [BLK_W-1:0]   blk,
  input  logic [WORD_W-1:0]  pwd,
  input  logic               pwd_en,
  output logic [FRAME_W-1:0] frame,
  output logic [LEN_W-1:0]   len,
  output logic               is_write
);
  always_comb begin
    is_write = (cmd == CMD_WRITE);
    frame    = '0;
    len      = '0;
    if (cmd == CMD_WRITE) begin
      if (pwd_en) begin
        frame = {2'b10, pwd, 1'b0, data, blk};
        len   = LEN_W'(FRAME_W);
      end else begin
        frame = {2'b10, 1'b0, data, blk, {WORD_W{1'b0}}};
        len   = LEN_W'(FRAME_W - WORD_W);
      end
    end else if (cmd == CMD_READ) begin
      if (pwd_en) begin
        frame = {2'b10, pwd, 1'b0, blk, {WORD_W{1'b0}}};
        len   = LEN_W'(3 + WORD_W + BLK_W);
      end else begin
        frame = {2'b10, 1'b0, blk, {(2*WORD_W){1'b0}}};
        len   = LEN_W'(3 + BLK_W);
      end
    end else begin
      frame = {2'b11, {(FRAME_W-2){1'b0}}};
      len   = LEN_W'(2);
    end
  end
endmodule

// File: rtl/pgap_downlink_enc.sv
module pgap_downlink_enc
  import pgap_pkg::*;
#(
  parameter int CLK_PER_US = 50,
  parameter int START_US   = 248,
  parameter int ZERO_US    = 144,
  parameter int ONE_US     = 400,
  parameter int GAP_US     = 160,
  parameter int HOLD_US    = 20000,
  parameter int LISTEN_US  = 416,
  parameter int ADDR_IN_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [1:0]           req_cmd,
  input  logic [WORD_W-1:0]    req_data,
  input  logic [ADDR_IN_W-1:0] req_addr,
  input  logic [WORD_W-1:0]    req_pwd,
  input  logic                 req_pwd_en,
  output logic                 carrier_en,
  output logic                 busy,
  output logic                 done,
  output logic                 capture_start
);
  localparam int DUR_W = $clog2(START_US + ZERO_US + ONE_US + GAP_US
                                + HOLD_US + LISTEN_US + 1);
  localparam logic [DUR_W-1:0] D_START  = DUR_W'(START_US);
  localparam logic [DUR_W-1:0] D_ZERO   = DUR_W'(ZERO_US);
  localparam logic [DUR_W-1:0] D_ONE    = DUR_W'(ONE_US);
  localparam logic [DUR_W-1:0] D_GAP    = DUR_W'(GAP_US);
  localparam logic [DUR_W-1:0] D_HOLD   = DUR_W'(HOLD_US);
  localparam logic [DUR_W-1:0] D_LISTEN = DUR_W'(LISTEN_US);

  pgap_state_e        state;
  logic [FRAME_W-1:0] shreg;
  logic [LEN_W-1:0]   bits_left;
  logic               post_write;

  logic [FRAME_W-1:0] new_frame;
  logic [LEN_W-1:0]   new_len;
  logic               new_is_write;
  logic               unused_addr;

  logic               tick;
  logic               expire;
  logic               seg_load;
  logic [DUR_W-1:0]   seg_us;
  logic               accept;
  logic               last_bit;

  assign unused_addr = ^req_addr;
  assign accept      = (state == ST_IDLE) && req_valid;
  assign last_bit    = (bits_left == LEN_W'(1));

  pgap_frame_build u_build (
    .cmd      (req_cmd),
    .data     (req_data),
    .blk      (req_addr[BLK_W-1:0]),
    .pwd      (req_pwd),
    .pwd_en   (req_pwd_en),
    .frame    (new_frame),
    .len      (new_len),
    .is_write (new_is_write)
  );

  pgap_us_tick #(.DIV(CLK_PER_US)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (seg_load),
    .tick    (tick)
  );

  pgap_seg_timer #(.DUR_W(DUR_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (seg_load),
    .load_us (seg_us),
    .tick    (tick),
    .expire  (expire)
  );

  // Next segment length, picked by the state being left.
  always_comb begin
    seg_load = accept || (expire && state != ST_IDLE);
    seg_us   = '0;
    unique case (state)
      ST_IDLE:  seg_us = D_START;
      ST_SGAP:  seg_us = shreg[FRAME_W-1] ? D_ONE : D_ZERO;
      ST_MARK:  seg_us = D_GAP;
      ST_SPACE: begin
        if (last_bit)            seg_us = post_write ? D_HOLD : D_LISTEN;
        else if (shreg[FRAME_W-2]) seg_us = D_ONE;
        else                     seg_us = D_ZERO;
      end
      default:  seg_us = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      shreg         <= '0;
      bits_left     <= '0;
      post_write    <= 1'b0;
      done          <= 1'b0;
      capture_start <= 1'b0;
    end else begin
      done          <= 1'b0;
      capture_start <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          shreg      <= new_frame;
          bits_left  <= new_len;
          post_write <= new_is_write;
          state      <= ST_SGAP;
        end
        ST_SGAP:  if (expire) state <= ST_MARK;
        ST_MARK:  if (expire) state <= ST_SPACE;
        ST_SPACE: if (expire) begin
          if (last_bit) begin
            state <= ST_POST;
          end else begin
            shreg     <= {shreg[FRAME_W-2:0], 1'b0};
            bits_left <= bits_left - 1'b1;
            state     <= ST_MARK;
          end
        end
        ST_POST: if (expire) begin
          state         <= ST_IDLE;
          done          <= 1'b1;
          capture_start <= !post_write;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state != ST_IDLE);
  assign req_ready  = (state == ST_IDLE);
  assign carrier_en = (state == ST_MARK) || (state == ST_POST);
endmodule

// File: rtl/pgap_downlink_chk.sv
module pgap_downlink_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic carrier_en,
  input logic busy,
  input logic done,
  input logic capture_start
);
  a_r1_idle_carrier_off: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !carrier_en);

  a_r2_accept_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid && req_ready));

  a_r2_no_ready_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r12_done_after_window: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !carrier_en && $past(busy) && $past(carrier_en)));

  a_r11_strobe_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    capture_start |-> done);
endmodule

bind pgap_downlink_enc pgap_downlink_chk u_chk (.*);

// File: tb/test_pgap_downlink_enc.sv
module test_pgap_downlink_enc;
  localparam int P       = 2;
  localparam int T_START = 248;
  localparam int T_ZERO  = 144;
  localparam int T_ONE   = 400;
  localparam int T_GAP   = 160;
  localparam int T_HOLD  = 150;
  localparam int T_LIST  = 416;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_cmd = 2'b00;
  logic [31:0] req_data = '0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_pwd = '0;
  logic        req_pwd_en = 1'b0;
  logic        carrier_en, busy, done, capture_start;

  always #2 clk = ~clk;

  pgap_downlink_enc #(
    .CLK_PER_US(P), .START_US(T_START), .ZERO_US(T_ZERO), .ONE_US(T_ONE),
    .GAP_US(T_GAP), .HOLD_US(T_HOLD), .LISTEN_US(T_LIST), .ADDR_IN_W(8)
  ) i_pgap_downlink_enc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_data(req_data), .req_addr(req_addr),
    .req_pwd(req_pwd), .req_pwd_en(req_pwd_en), .carrier_en(carrier_en),
    .busy(busy), .done(done), .capture_start(capture_start)
  );

  typedef struct { bit lvl; int len; string tag; } run_t;
  run_t exp_q[$];
  bit   cap_q[$];

  int checks = 0;
  int errors = 0;
  int frames_issued = 0;
  int frames_done = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // Scoreboard monitor: measures carrier runs during busy.
  bit prev_busy = 1'b0;
  bit cur_lvl   = 1'b0;
  int run_len   = 0;

  task automatic close_run();
    run_t e;
    if (exp_q.size() == 0) begin
      check(1'b0, "R4 unexpected carrier run (len)", run_len, 0);
      return;
    end
    e = exp_q.pop_front();
    check(cur_lvl == e.lvl, {e.tag, " level"}, int'(cur_lvl), int'(e.lvl));
    check(run_len == e.len, {e.tag, " length"}, run_len, e.len);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !prev_busy) begin
        cur_lvl = carrier_en;
        run_len = 1;
      end else if (busy) begin
        if (carrier_en == cur_lvl) run_len++;
        else begin
          close_run();
          cur_lvl = carrier_en;
          run_len = 1;
        end
      end else if (prev_busy) begin
        close_run();
        check(done == 1'b1, "R12 done at end of window", int'(done), 1);
        if (cap_q.size() != 0) begin
          bit ec;
          ec = cap_q.pop_front();
          check(capture_start == ec, "R10/R11 capture strobe", int'(capture_start), int'(ec));
        end
        frames_done++;
      end else begin
        if (carrier_en || done || capture_start) begin
          errors++;
          $display("FAIL R1 idle outputs: carrier %0d done %0d cap %0d expected 0 0 0",
                   carrier_en, done, capture_start);
        end
      end
      prev_busy = busy;
    end
  end

  task automatic issue(input logic [1:0] cmd, input logic [31:0] data,
                       input logic [7:0] addr, input logic [31:0] pwd,
                       input bit pwd_en, input string tag);
    bit q[$];
    bit wr;
    wr = (cmd == 2'b00);
    q.push_back(1'b1);
    q.push_back(cmd[1]);
    if (!cmd[1]) begin
      if (pwd_en) for (int i = 31; i >= 0; i--) q.push_back(pwd[i]);
      q.push_back(1'b0);
      if (wr) for (int i = 31; i >= 0; i--) q.push_back(data[i]);
      for (int i = 2; i >= 0; i--) q.push_back(addr[i]);
    end
    exp_q.push_back('{1'b0, T_START * P, "R3 R13 start gap"});
    foreach (q[k]) begin
      exp_q.push_back('{1'b1, (q[k] ? T_ONE : T_ZERO) * P, {"R4 bit ", tag}});
      exp_q.push_back('{1'b0, T_GAP * P, "R4 gap"});
    end
    if (wr) exp_q.push_back('{1'b1, T_HOLD * P, "R10 hold window"});
    else    exp_q.push_back('{1'b1, T_LIST * P, "R11 listen window"});
    cap_q.push_back(!wr);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_cmd = cmd; req_data = data; req_addr = addr;
    req_pwd = pwd; req_pwd_en = pwd_en; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    frames_issued++;
  endtask

  task automatic wait_frame();
    while (frames_done < frames_issued) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(carrier_en == 0, "R1 reset carrier", int'(carrier_en), 0);
    check(busy == 0, "R1 reset busy", int'(busy), 0);
    check(req_ready == 1, "R1 reset ready", int'(req_ready), 1);
    check(done == 0 && capture_start == 0, "R1 reset pulses", int'(done), 0);

    // R5 R8: write with password
    issue(2'b00, 32'h0000_0081, 8'h05, 32'h8000_0001, 1'b1, "R5 R8 write pwd");
    wait_frame();
    // R5 R9: write without password, upper address bits set
    issue(2'b00, 32'h0000_0003, 8'hFA, 32'hFFFF_FFFF, 1'b0, "R5 R9 write");
    wait_frame();
    // R6 R8 R9: read with password
    issue(2'b01, 32'hFFFF_FFFF, 8'hFF, 32'h0000_0001, 1'b1, "R6 R8 read pwd");
    wait_frame();
    // R6 R2: read without password, with a request offered while busy
    issue(2'b01, 32'h0, 8'h03, 32'h0, 1'b0, "R6 R2 read");
    repeat (300) @(negedge clk);
    begin
      int ready_seen;
      ready_seen = 0;
      req_cmd = 2'b00; req_pwd_en = 1'b1; req_data = 32'hFFFF_FFFF; req_valid = 1'b1;
      for (int i = 0; i < 10; i++) begin
        if (req_ready) ready_seen++;
        @(negedge clk);
      end
      req_valid = 1'b0;
      check(ready_seen == 0, "R2 ready low while busy", ready_seen, 0);
    end
    wait_frame();
    // R7: trace reads, both encodings
    issue(2'b10, 32'hFFFF_FFFF, 8'h07, 32'hFFFF_FFFF, 1'b1, "R7 trace");
    wait_frame();
    issue(2'b11, 32'h0, 8'h00, 32'h0, 1'b0, "R7 trace alt");
    wait_frame();

    check(exp_q.size() == 0, "R4 all expected runs seen", exp_q.size(), 0);
    check(frames_done == 6, "R12 one done per command", frames_done, 6);
    check(!busy && req_ready && !carrier_en, "R1 idle at end", int'(busy), 0);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule